// File: doc/BRIEF.md
# Scatter Segment to PRD Descriptor Splitter

The block turns an ordered stream of memory segments, each given as a start address and a byte length, into a stream of physical-region descriptors for a bus-mastering disk DMA engine. Every descriptor is a pair of 32-bit words: a start address and a count word whose low half carries the byte count and whose bit 31 marks the end of the table. No descriptor may span a 64 KB address window, so a segment that runs across one or more window edges is cut into several pieces. A request is the run of segments up to and including the one flagged as last.

Two options are taken from the mode inputs on the first segment of each request. The first is a split mode for controllers that read a count of zero as zero bytes rather than 64 KB: it emits such a piece as two 32 KB descriptors. The second is a word-count mode that stores the count as (bytes / 4 - 1) in the upper half of the count word and sets no end-of-table bit. The block keeps each new descriptor in a holding stage until the next one appears or the request ends, so it can tag the final one. It counts table slots against a parameter limit. At the end of each request it issues a one-cycle report that says either success with the table length, or one error: overflow, empty request or misaligned segment. Any error tells the requester to fall back to programmed I/O.

Top module: `prd_seg_splitter`

## Requirements
- R1: Each descriptor covers min(0x10000 - addr[15:0], remaining bytes) of its segment, starting at the segment's current address. Descriptors leave in address order and none crosses a 64 KB boundary.
- R2: In normal mode the count word holds the byte count modulo 0x10000 in bits 15:0, so a full 64 KB piece encodes as 0x0000. Bits 30:16 are zero.
- R3: In normal mode with split mode set, a full 64 KB piece at address A is emitted as (A, 0x00008000) followed by (A + 0x8000, 0x00008000). It uses two table slots.
- R4: In normal mode, bit 31 of the count word is set on the final descriptor of a successful request and on no other descriptor.
- R5: In word-count mode the count word is {((bytes mod 0x10000) / 4 - 1) mod 0x10000, 16'h0000}, bit 31 gets no end-of-table meaning, and split mode has no effect.
- R6: A request that needs more than MAX_ENT table slots reports error bit 0 (overflow). Only the first MAX_ENT - 1 descriptors are delivered. A request that needs exactly MAX_ENT slots succeeds.
- R7: A request whose segments all have zero length delivers no descriptor and reports error bit 1 (empty).
- R8: A segment with addr[0] or len[0] set (normal mode), or with any of addr[1:0] or len[1:0] set (word-count mode), reports error bit 2 (misaligned). The descriptor still held is dropped. The rest of the request's segments are taken and discarded.
- R9: One cycle after the final descriptor is accepted downstream, rpt_valid pulses for one cycle. On success it comes with rpt_ok = 1, rpt_err = 0 and rpt_count equal to the number of descriptors. On failure it comes with rpt_ok = 0, exactly one rpt_err bit set and rpt_count = 0.
- R10: While desc_valid is high and desc_ready is low, the descriptor holds steady. A zero-length segment that is not last adds nothing to the table.
- R11: mode_split and mode_alt are sampled only on the first segment of a request. A new request starts from an empty slot count.
- R12: While reset is applied and until it has been released internally, seg_ready, desc_valid and rpt_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment taken when both high |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | 32 | Segment length in bytes |
| seg_last | input | 1 | Segment closes the request |
| mode_split | input | 1 | Split full 64 KB pieces into halves |
| mode_alt | input | 1 | Word-count encoding |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Descriptor taken when both high |
| desc_addr | output | 32 | Descriptor address word |
| desc_word | output | 32 | Descriptor count/flag word |
| rpt_valid | output | 1 | One-cycle end-of-request report |
| rpt_ok | output | 1 | Table built successfully |
| rpt_err | output | 3 | Bit 0 overflow, bit 1 empty, bit 2 misaligned |
| rpt_count | output | $clog2(MAX_ENT+1) | Descriptor count on success |

## Verification
Two actions can land on the same edge. One is tagging the held final descriptor with the end-of-table bit and moving it into the output register. The other is the downstream side taking the previous descriptor out of that register. Error detection (overflow or misalignment) can likewise meet an output stall that leaves a released descriptor waiting. The bench drives desc_ready with random back-pressure and offers segments with random gaps, so these events fall in every relative order. Each request's delivered stream, its end-of-table placement and its report are then compared against a model that computes the table directly from the requirements.

// File: rtl/prd_split_pkg.sv
package prd_split_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 16;
  localparam logic [WORD_W-1:0] WINDOW   = 32'h0001_0000;
  localparam logic [WORD_W-1:0] HALF_WIN = 32'h0000_8000;
  localparam int unsigned EOT_BIT = 31;
  localparam int unsigned ERR_W   = 3;
  localparam int unsigned E_OVF   = 0;
  localparam int unsigned E_EMPTY = 1;
  localparam int unsigned E_ALIGN = 2;

  typedef enum logic [2:0] {
    ST_SEG   = 3'd0,
    ST_RUN   = 3'd1,
    ST_FIN   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_RPT   = 3'd4
  } split_st_e;
endpackage

// File: rtl/prd_rst_sync.sv
module prd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc
  import prd_split_pkg::*;
(
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [WORD_W-1:0] rem,
  input  logic              half,
  input  logic              alt_mode,
  input  logic              split_mode,
  output logic [WORD_W-1:0] d_addr,
  output logic [WORD_W-1:0] d_word,
  output logic [WORD_W-1:0] step,
  output logic              piece_done
);
  logic [WORD_W-1:0]  room;
  logic [WORD_W-1:0]  chunk;
  logic [FIELD_W-1:0] field;
  logic [FIELD_W-1:0] alt_cnt;
  logic               two_part;

  always_comb begin
    // bytes left before the next 64 KB window edge
    room     = WINDOW - {{(WORD_W-FIELD_W){1'b0}}, cur_addr[FIELD_W-1:0]};
    chunk    = (rem < room) ? rem : room;
    field    = chunk[FIELD_W-1:0];
    alt_cnt  = {2'b00, field[FIELD_W-1:2]} - FIELD_W'(1);
    two_part = split_mode && !alt_mode && (field == '0);
    if (two_part) begin
      d_addr     = cur_addr + (half ? HALF_WIN : '0);
      d_word     = HALF_WIN;
      step       = WINDOW;
      piece_done = half;
    end else begin
      d_addr     = cur_addr;
      d_word     = alt_mode ? {alt_cnt, {FIELD_W{1'b0}}} : {{FIELD_W{1'b0}}, field};
      step       = chunk;
      piece_done = 1'b1;
    end
  end
endmodule

// File: rtl/prd_limit_cnt.sv
module prd_limit_cnt #(
  parameter int unsigned MAX_ENT = 256,
  localparam int unsigned CW = $clog2(MAX_ENT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          at_limit
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || inc) cnt <= cnt_d;
  end

  assign at_limit = (cnt == CW'(MAX_ENT));
endmodule

// File: rtl/prd_tag_stage.sv
module prd_tag_stage
  import prd_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_addr,
  input  logic [WORD_W-1:0] push_word,
  input  logic              seal,
  input  logic              seal_eot,
  input  logic              flush,
  input  logic              out_ready,
  output logic              hold_valid,
  output logic              out_free,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_addr,
  output logic [WORD_W-1:0] out_word
);
  logic [WORD_W-1:0] hold_addr, hold_word;
  logic              move;
  logic              hold_v_d, out_v_d;
  logic [WORD_W-1:0] tagged_word;

  always_comb begin
    move        = hold_valid && (push || seal);
    out_free    = !out_valid || out_ready;
    tagged_word = hold_word;
    if (seal && seal_eot) tagged_word[EOT_BIT] = 1'b1;
    out_v_d = out_valid;
    if (move)                        out_v_d = 1'b1;
    else if (out_valid && out_ready) out_v_d = 1'b0;
    hold_v_d = hold_valid;
    if (push)               hold_v_d = 1'b1;
    else if (seal || flush) hold_v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      hold_valid <= hold_v_d;
      out_valid  <= out_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_word <= '0;
    end else if (push) begin
      hold_addr <= push_addr;
      hold_word <= push_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_word <= '0;
    end else if (move) begin
      out_addr <= hold_addr;
      out_word <= tagged_word;
    end
  end
endmodule

// File: rtl/prd_seg_splitter.sv
module prd_seg_splitter
  import prd_split_pkg::*;
#(
  parameter int unsigned MAX_ENT = 256,
  localparam int unsigned CW = $clog2(MAX_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [WORD_W-1:0] seg_addr,
  input  logic [WORD_W-1:0] seg_len,
  input  logic              seg_last,
  input  logic              mode_split,
  input  logic              mode_alt,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [WORD_W-1:0] desc_addr,
  output logic [WORD_W-1:0] desc_word,
  output logic              rpt_valid,
  output logic              rpt_ok,
  output logic [ERR_W-1:0]  rpt_err,
  output logic [CW-1:0]     rpt_count
);
  logic rst_n_i;

  split_st_e         state_q, state_d;
  logic [WORD_W-1:0] addr_q, addr_d, rem_q, rem_d;
  logic              half_q, half_d, last_q, last_d, open_q, open_d;
  logic              m_split, m_alt, mode_en;
  logic [ERR_W-1:0]  err_q, err_d;

  logic [WORD_W-1:0] c_addr, c_word, c_step, rem_after;
  logic              c_done;
  logic [CW-1:0]     ent_cnt;
  logic              at_limit, cnt_inc, cnt_clr;
  logic              hold_v, out_free, push, seal, flush;
  logic              seg_fire, misaligned, eff_alt;

  prd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  prd_chunk_calc u_calc (
    .cur_addr(addr_q), .rem(rem_q), .half(half_q),
    .alt_mode(m_alt), .split_mode(m_split),
    .d_addr(c_addr), .d_word(c_word), .step(c_step), .piece_done(c_done)
  );

  prd_limit_cnt #(.MAX_ENT(MAX_ENT)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .inc(cnt_inc), .clr(cnt_clr),
    .cnt(ent_cnt), .at_limit(at_limit)
  );

  prd_tag_stage u_tag (
    .clk(clk), .rst_n(rst_n_i),
    .push(push), .push_addr(c_addr), .push_word(c_word),
    .seal(seal), .seal_eot(!m_alt), .flush(flush),
    .out_ready(desc_ready), .hold_valid(hold_v), .out_free(out_free),
    .out_valid(desc_valid), .out_addr(desc_addr), .out_word(desc_word)
  );

  always_comb begin
    seg_ready  = rst_n_i && ((state_q == ST_SEG) || (state_q == ST_DRAIN));
    seg_fire   = seg_valid && seg_ready;
    eff_alt    = open_q ? m_alt : mode_alt;
    misaligned = eff_alt ? ((|seg_addr[1:0]) || (|seg_len[1:0]))
                         : (seg_addr[0] || seg_len[0]);
    rem_after  = rem_q - c_step;
    rpt_valid  = (state_q == ST_RPT) && !desc_valid;
    rpt_ok     = (err_q == '0);
    rpt_err    = err_q;
    rpt_count  = (err_q == '0) ? ent_cnt : '0;
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    half_d  = half_q;
    last_d  = last_q;
    open_d  = open_q;
    err_d   = err_q;
    mode_en = 1'b0;
    push    = 1'b0;
    seal    = 1'b0;
    flush   = 1'b0;
    cnt_inc = 1'b0;
    cnt_clr = 1'b0;
    unique case (state_q)
      ST_SEG: begin
        if (seg_fire) begin
          open_d  = 1'b1;
          mode_en = !open_q;
          if (misaligned) begin
            err_d[E_ALIGN] = 1'b1;
            flush   = 1'b1;
            state_d = seg_last ? ST_RPT : ST_DRAIN;
          end else if (seg_len == '0) begin
            if (seg_last) state_d = ST_FIN;
          end else begin
            addr_d  = seg_addr;
            rem_d   = seg_len;
            last_d  = seg_last;
            half_d  = 1'b0;
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (at_limit) begin
          err_d[E_OVF] = 1'b1;
          flush   = 1'b1;
          state_d = last_q ? ST_RPT : ST_DRAIN;
        end else if (!hold_v || out_free) begin
          push    = 1'b1;
          cnt_inc = 1'b1;
          if (c_done) begin
            addr_d = addr_q + c_step;
            rem_d  = rem_after;
            half_d = 1'b0;
            if (rem_after == '0) state_d = last_q ? ST_FIN : ST_SEG;
          end else begin
            half_d = 1'b1;
          end
        end
      end
      ST_FIN: begin
        if (ent_cnt == '0) begin
          err_d[E_EMPTY] = 1'b1;
          state_d = ST_RPT;
        end else if (out_free) begin
          seal    = 1'b1;
          state_d = ST_RPT;
        end
      end
      ST_DRAIN: begin
        if (seg_fire && seg_last) state_d = ST_RPT;
      end
      ST_RPT: begin
        if (!desc_valid) begin
          cnt_clr = 1'b1;
          err_d   = '0;
          open_d  = 1'b0;
          state_d = ST_SEG;
        end
      end
      default: state_d = ST_SEG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_SEG;
      addr_q  <= '0;
      rem_q   <= '0;
      half_q  <= 1'b0;
      last_q  <= 1'b0;
      open_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      half_q  <= half_d;
      last_q  <= last_d;
      open_q  <= open_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      m_split <= 1'b0;
      m_alt   <= 1'b0;
    end else if (mode_en) begin
      m_split <= mode_split;
      m_alt   <= mode_alt;
    end
  end
endmodule

// File: rtl/prd_seg_splitter_chk.sv
module prd_seg_splitter_chk #(
  parameter int unsigned MAX_ENT = 256,
  localparam int unsigned CW = $clog2(MAX_ENT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic [31:0]   desc_addr,
  input logic [31:0]   desc_word,
  input logic          rpt_valid,
  input logic          rpt_ok,
  input logic [2:0]    rpt_err,
  input logic          alt_q,
  input logic [CW-1:0] cnt
);
  logic [17:0] span_len;
  logic [17:0] span_end;

  always_comb begin
    if (alt_q) span_len = {desc_word[31:16] + 16'd1, 2'b00};
    else       span_len = (desc_word[15:0] == 16'h0) ? 18'h10000 : {2'b00, desc_word[15:0]};
    if (alt_q && desc_word[31:16] == 16'hFFFF) span_len = 18'h10000;
    span_end = {2'b00, desc_addr[15:0]} + span_len;
  end

  assert_desc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) && $stable(desc_word));

  assert_no_cross_R1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> span_end <= 18'h10000);

  assert_norm_mid_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !alt_q |-> desc_word[30:16] == 15'h0);

  assert_alt_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && alt_q |-> desc_word[15:0] == 16'h0);

  assert_rpt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |=> !rpt_valid);

  assert_rpt_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_ok ? (rpt_err == 3'b000) : ($countones(rpt_err) == 1)));

  assert_rpt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> !desc_valid);

  assert_cnt_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_ENT));
endmodule

bind prd_seg_splitter prd_seg_splitter_chk #(.MAX_ENT(MAX_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_addr(desc_addr), .desc_word(desc_word), .rpt_valid(rpt_valid),
  .rpt_ok(rpt_ok), .rpt_err(rpt_err), .alt_q(m_alt), .cnt(ent_cnt)
);

// File: tb/tb_prd_seg_splitter.sv
module tb_prd_seg_splitter;
  localparam int unsigned MAX_ENT = 256;
  localparam int unsigned CW = $clog2(MAX_ENT + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic seg_valid, seg_ready, seg_last, mode_split, mode_alt;
  logic [31:0] seg_addr, seg_len;
  logic desc_valid, desc_ready;
  logic [31:0] desc_addr, desc_word;
  logic rpt_valid, rpt_ok;
  logic [2:0] rpt_err;
  logic [CW-1:0] rpt_count;

  prd_seg_splitter #(.MAX_ENT(MAX_ENT)) dut (
    .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .mode_split(mode_split), .mode_alt(mode_alt),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_word(desc_word),
    .rpt_valid(rpt_valid), .rpt_ok(rpt_ok), .rpt_err(rpt_err), .rpt_count(rpt_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [31:0] sa[$], sl[$];
  logic [31:0] exp_a[$], exp_w[$], got_a[$], got_w[$];
  logic [2:0]  exp_err;
  int          exp_gen;

  task automatic check_eq(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic add_exp(logic [31:0] a, logic [31:0] w);
    exp_a.push_back(a);
    exp_w.push_back(w);
  endtask

  // table computed straight from R1..R8
  task automatic model(bit sp, bit al);
    logic [31:0] a, r, room, c;
    logic [15:0] f, ac;
    exp_a.delete(); exp_w.delete();
    exp_err = 3'b000;
    exp_gen = 0;
    foreach (sa[i]) begin
      a = sa[i];
      r = sl[i];
      if (al ? ((a[1:0] != 0) || (r[1:0] != 0)) : (a[0] || r[0])) begin
        exp_err = 3'b100;
        return;
      end
      while (r != 0) begin
        room = 32'h10000 - {16'h0, a[15:0]};
        c = (r < room) ? r : room;
        f = c[15:0];
        if (sp && !al && f == 16'h0) begin
          for (int h = 0; h < 2; h++) begin
            if (exp_gen >= MAX_ENT) begin exp_err = 3'b001; return; end
            add_exp(a + (h == 1 ? 32'h8000 : 32'h0), 32'h8000);
            exp_gen++;
          end
        end else begin
          if (exp_gen >= MAX_ENT) begin exp_err = 3'b001; return; end
          ac = {2'b00, f[15:2]} - 16'd1;
          add_exp(a, al ? {ac, 16'h0} : {16'h0, f});
          exp_gen++;
        end
        a = a + c;
        r = r - c;
      end
    end
    if (exp_gen == 0) exp_err = 3'b010;
    else if (!al) exp_w[exp_w.size()-1][31] = 1'b1;
  endtask

  task automatic run_req(bit sp, bit al, string tag);
    int idx;
    bit done;
    logic ok_s;
    logic [2:0] err_s;
    logic [CW-1:0] cnt_s;
    int n_exp;
    model(sp, al);
    got_a.delete(); got_w.delete();
    idx = 0;
    done = 0;
    while (!done) begin
      @(negedge clk);
      if (rpt_valid) begin
        ok_s = rpt_ok; err_s = rpt_err; cnt_s = rpt_count;
        seg_valid = 1'b0;
        done = 1;
      end else begin
        desc_ready = ($urandom % 4) != 0;
        if (idx < sa.size()) begin
          seg_valid  = ($urandom % 4) != 0;
          seg_addr   = sa[idx];
          seg_len    = sl[idx];
          seg_last   = (idx == sa.size() - 1);
          // later segments carry the opposite modes: they must be ignored (R11)
          mode_split = (idx == 0) ? sp : !sp;
          mode_alt   = (idx == 0) ? al : !al;
        end else begin
          seg_valid = 1'b0;
        end
        if (seg_valid && seg_ready) idx++;
        if (desc_valid && desc_ready) begin
          got_a.push_back(desc_addr);
          got_w.push_back(desc_word);
        end
      end
    end
    if (exp_err == 3'b000) begin
      check_eq(tag, "R9 ok", ok_s, 1);
      check_eq(tag, "R9 count", cnt_s, exp_a.size());
      n_exp = exp_a.size();
    end else begin
      check_eq(tag, "R6/R7/R8 err code", err_s, exp_err);
      check_eq(tag, "R9 ok low", ok_s, 0);
      check_eq(tag, "R9 count zero", cnt_s, 0);
      n_exp = (exp_gen > 0) ? exp_gen - 1 : 0;
    end
    check_eq(tag, "R1 delivered size", got_a.size(), n_exp);
    for (int i = 0; i < got_a.size() && i < n_exp; i++) begin
      check_eq(tag, "R1 addr", got_a[i], exp_a[i]);
      check_eq(tag, "R2/R3/R4/R5 word", got_w[i], exp_w[i]);
    end
  endtask

  task automatic seg(logic [31:0] a, logic [31:0] l);
    sa.push_back(a);
    sl.push_back(l);
  endtask

  task automatic clr_segs();
    sa.delete(); sl.delete();
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0;
    seg_valid = 0; seg_addr = 0; seg_len = 0; seg_last = 0;
    mode_split = 0; mode_alt = 0; desc_ready = 0;
    repeat (3) @(negedge clk);
    check_eq("reset", "R12 seg_ready", seg_ready, 0);
    check_eq("reset", "R12 desc_valid", desc_valid, 0);
    check_eq("reset", "R12 rpt_valid", rpt_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("reset", "R12 seg_ready before sync release", seg_ready, 0);
    repeat (3) @(negedge clk);
    check_eq("reset", "R12 seg_ready after release", seg_ready, 1);

    clr_segs(); seg(32'h0001_FFF0, 32'h40);                 run_req(0, 0, "R1 window cross");
    clr_segs(); seg(32'h0003_0000, 32'h10000);              run_req(0, 0, "R2 full 64K");
    clr_segs(); seg(32'h0003_0000, 32'h18000);              run_req(1, 0, "R3 split");
    clr_segs(); seg(32'h0005_0000, 32'h10004);              run_req(1, 0 | 1, "R5 word mode");
    clr_segs(); seg(32'h0000_1000, 32'h0);                  run_req(0, 0, "R7 empty");
    clr_segs(); seg(32'h1000, 32'h20); seg(32'h2000, 0); seg(32'h3000, 32'h10);
                                                            run_req(0, 0, "R10 zero mid");
    clr_segs(); seg(32'h0000_1001, 32'h10);                 run_req(0, 0, "R8 odd addr");
    clr_segs(); seg(32'h0000_1002, 32'h8);                  run_req(0, 1, "R8 word align");
    clr_segs(); seg(32'h4000, 32'h20); seg(32'h5000, 32'h11); seg(32'h6000, 32'h10);
                                                            run_req(0, 0, "R8 mid request");
    clr_segs(); seg(32'h0, 32'h0100_0000);                  run_req(0, 0, "R6 exact limit");
    clr_segs(); seg(32'h0, 32'h0101_0000);                  run_req(0, 0, "R6 overflow");
    clr_segs(); seg(32'h0, 32'h0080_0002);                  run_req(1, 0, "R6 R3 split overflow");
    clr_segs(); seg(32'hFFFF_FFF0, 32'h20);                 run_req(0, 0, "R1 address wrap");

    for (int t = 0; t < 80; t++) begin
      bit sp, al;
      int ns;
      logic [31:0] a, l, m;
      sp = $urandom % 2;
      al = ($urandom % 4) == 0;
      m  = al ? 32'hFFFF_FFFC : 32'hFFFF_FFFE;
      ns = 1 + $urandom % 4;
      clr_segs();
      for (int s = 0; s < ns; s++) begin
        a = $urandom;
        if ($urandom % 3 == 0) a[15:0] = 16'hFFFF - ($urandom % 16'h100);
        if ($urandom % 5 == 0) a[15:0] = 16'h0;
        case ($urandom % 5)
          0: l = $urandom % 32'h200;
          1: l = 32'h10000;
          2: l = $urandom % 32'h30000;
          3: l = 32'h0;
          default: l = $urandom % 32'h12000;
        endcase
        a = a & m;
        l = l & m;
        if ($urandom % 25 == 0) a[0] = 1'b1;
        seg(a, l);
      end
      run_req(sp, al, $sformatf("R11 random %0d", t));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule